// File: doc/BRIEF.md
# Address and Control Bus Parity Checker

This block sits on the request path between a processor and a RAM wrapper. In every address phase the processor sends a set of parity bits along with the address and the control signals. The block recomputes those bits from the address and control fields and compares them with the received ones. If any bit differs, the access is answered with a bus error. A one-cycle pulse also goes to the chip's error aggregator.

The first failing access is recorded. A sticky flag is set, and the failing address and a per-bit syndrome are saved. Later failures still raise the error outputs, but they do not overwrite the record while the flag is set. Software reads the record through a small two-word register port. It clears the flag, and optionally the syndrome bits, with write-one-to-clear. A configuration input selects even or odd parity. It is sampled together with each address phase and must be held steady while an access is in flight.

Top module: `acp_parity_checker`

## Requirements
- R1: The parity bits are arranged as follows. Bit g of `req_par` covers `req_addr[8g+7:8g]` for each address byte g (g = 0..3). Bit 4 covers the control group `{req_priv, req_size[1:0], req_wr}`. The expected bit is the XOR of its group when `odd_sel` is 0, and the inverse of that XOR when `odd_sel` is 1.
- R2: `bus_err` and `err_sig` stay low in the cycle after an address phase when `req_valid` was low or when every received bit matched.
- R3: When an address phase has `req_valid` high and at least one parity bit mismatches, `bus_err` is high for exactly the following clock cycle.
- R4: `err_sig` pulses in the same cycle as `bus_err`, for every detected mismatch.
- R5: A mismatch sets the status flag (status word bit 8) when the flag is clear. It also captures the address, read at register index 1, and the mismatch pattern, read in status bits [7:0] with bit g set for each mismatching parity bit.
- R6: While the flag is set, further mismatches leave the captured address and syndrome unchanged.
- R7: A write to index 0 with data bit 8 set clears the flag. Data bits [7:0] clear the matching syndrome bits. A write with bit 8 at 0 keeps the flag. A write to index 1 changes nothing.
- R8: When a flag-clearing write and a new mismatch occur in the same cycle, the new error is captured and the flag stays set.
- R9: After reset the error outputs are low, and both register words read 0.
- R10: The polarity used for an access is the value of `odd_sel` in that access's address phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| odd_sel | input | 1 | Parity polarity: 0 even, 1 odd |
| req_valid | input | 1 | Address phase valid |
| req_addr | input | 32 | Request address |
| req_wr | input | 1 | Write enable of the request |
| req_size | input | 2 | Access size code |
| req_priv | input | 1 | Privileged access |
| req_par | input | 5 | Parity bits sent with the request |
| bus_err | output | 1 | Bus error response, one cycle after the phase |
| err_sig | output | 1 | Address-parity failure pulse to the error aggregator |
| reg_wr | input | 1 | Register write strobe |
| reg_idx | input | 1 | Register index: 0 status, 1 captured address |
| reg_wdata | input | 9 | Write data (bit 8 flag clear, bits 7:0 syndrome clear) |
| reg_rdata | output | 32 | Read data of the selected register |

## Verification
The checker is driven first with correct parity under both polarities. This separates a correct XOR fold from an inverted or swapped polarity. Single-bit corruptions in each address byte and in the control group follow; they show that every group is wired to its own parity bit and reported in the right syndrome position. A second error arriving while the flag is set tells sticky capture apart from overwrite. Clearing writes with bit 8 low, writes to the address word, and a clear that lands in the same cycle as a new error separate the W1C decode and the set-over-clear priority. A long random run with mixed polarity, corruptions and clears is compared each cycle against a behavioural model.

// File: rtl/acp_pkg.sv
package acp_pkg;

  // Control group covered by the last parity bit, MSB first
  typedef struct packed {
    logic       priv;
    logic [1:0] size;
    logic       wr;
  } acp_ctrl_t;

  localparam int CTRL_W   = $bits(acp_ctrl_t);
  localparam int FLAG_BIT = 8;
  localparam int SYN_W    = 8;

  typedef enum logic {
    REG_STATUS  = 1'b0,
    REG_ERRADDR = 1'b1
  } acp_reg_e;

  // Parity of a zero-padded field; odd = 1 inverts the even result
  function automatic logic fold_parity(input logic [63:0] bits, input logic odd);
    return (^bits) ^ odd;
  endfunction

  // Status word layout: flag above the syndrome field
  function automatic logic [FLAG_BIT:0] pack_status(input logic flag,
                                                    input logic [SYN_W-1:0] syn);
    return {flag, syn};
  endfunction

endpackage

// File: rtl/acp_parity_gen.sv
module acp_parity_gen
  import acp_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int GROUP_W = 8,
  localparam int NGRP   = ADDR_W / GROUP_W,
  localparam int NPAR   = NGRP + 1
) (
  input  logic [ADDR_W-1:0] addr,
  input  acp_ctrl_t         ctrl,
  input  logic              odd_sel,
  output logic [NPAR-1:0]   exp_par
);

  for (genvar g = 0; g < NGRP; g++) begin : g_addr_grp
    assign exp_par[g] = fold_parity(64'(addr[g*GROUP_W +: GROUP_W]), odd_sel);
  end

  assign exp_par[NGRP] = fold_parity(64'(ctrl), odd_sel);

endmodule

// File: rtl/acp_compare.sv
module acp_compare #(
  parameter int NPAR = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            valid,
  input  logic [NPAR-1:0] exp_par,
  input  logic [NPAR-1:0] rcv_par,
  output logic [NPAR-1:0] mism,
  output logic            err_event,
  output logic            bus_err,
  output logic            esm_pulse
);

  assign mism      = exp_par ^ rcv_par;
  assign err_event = valid && (mism != '0);

  // Two separate flops: response path and error-signal path
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_err   <= 1'b0;
      esm_pulse <= 1'b0;
    end else begin
      bus_err   <= err_event;
      esm_pulse <= err_event;
    end
  end

endmodule

// File: rtl/acp_err_capture.sv
module acp_err_capture
  import acp_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int NPAR   = 5,
  parameter int REG_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              err_event,
  input  logic [NPAR-1:0]   mism,
  input  logic [ADDR_W-1:0] addr,
  input  logic              reg_wr,
  input  logic              reg_idx,
  input  logic [FLAG_BIT:0] reg_wdata,
  output logic              flag,
  output logic [ADDR_W-1:0] cap_addr,
  output logic [SYN_W-1:0]  syn,
  output logic              clear_req,
  output logic              capture_en,
  output logic [REG_W-1:0]  reg_rdata
);

  logic status_wr;

  assign status_wr  = reg_wr && (acp_reg_e'(reg_idx) == REG_STATUS);
  assign clear_req  = status_wr && reg_wdata[FLAG_BIT];
  // A new error wins over a clear in the same cycle
  assign capture_en = err_event && (!flag || clear_req);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag     <= 1'b0;
      cap_addr <= '0;
      syn      <= '0;
    end else begin
      if (capture_en) begin
        flag     <= 1'b1;
        cap_addr <= addr;
        syn      <= SYN_W'(mism);
      end else begin
        if (clear_req) flag <= 1'b0;
        if (status_wr) syn <= syn & ~reg_wdata[SYN_W-1:0];
      end
    end
  end

  always_comb begin
    if (acp_reg_e'(reg_idx) == REG_STATUS)
      reg_rdata = REG_W'(pack_status(flag, syn));
    else
      reg_rdata = REG_W'(cap_addr);
  end

endmodule

// File: rtl/acp_parity_checker.sv
module acp_parity_checker
  import acp_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int GROUP_W = 8,
  parameter int REG_W   = 32,
  localparam int NPAR   = ADDR_W / GROUP_W + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                odd_sel,
  input  logic                req_valid,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic                req_wr,
  input  logic [1:0]          req_size,
  input  logic                req_priv,
  input  logic [NPAR-1:0]     req_par,
  output logic                bus_err,
  output logic                err_sig,
  input  logic                reg_wr,
  input  logic                reg_idx,
  input  logic [FLAG_BIT:0]   reg_wdata,
  output logic [REG_W-1:0]    reg_rdata
);

  acp_ctrl_t         ctrl;
  logic [NPAR-1:0]   exp_par;
  logic [NPAR-1:0]   mism;
  logic              err_event;
  logic              flag;
  logic [ADDR_W-1:0] cap_addr;
  logic [SYN_W-1:0]  syn;
  logic              clear_req;
  logic              capture_en;

  assign ctrl = '{priv: req_priv, size: req_size, wr: req_wr};

  acp_parity_gen #(
    .ADDR_W (ADDR_W),
    .GROUP_W(GROUP_W)
  ) u_gen (
    .addr   (req_addr),
    .ctrl   (ctrl),
    .odd_sel(odd_sel),
    .exp_par(exp_par)
  );

  acp_compare #(
    .NPAR(NPAR)
  ) u_cmp (
    .clk      (clk),
    .rst_n    (rst_n),
    .valid    (req_valid),
    .exp_par  (exp_par),
    .rcv_par  (req_par),
    .mism     (mism),
    .err_event(err_event),
    .bus_err  (bus_err),
    .esm_pulse(err_sig)
  );

  acp_err_capture #(
    .ADDR_W(ADDR_W),
    .NPAR  (NPAR),
    .REG_W (REG_W)
  ) u_cap (
    .clk       (clk),
    .rst_n     (rst_n),
    .err_event (err_event),
    .mism      (mism),
    .addr      (req_addr),
    .reg_wr    (reg_wr),
    .reg_idx   (reg_idx),
    .reg_wdata (reg_wdata),
    .flag      (flag),
    .cap_addr  (cap_addr),
    .syn       (syn),
    .clear_req (clear_req),
    .capture_en(capture_en),
    .reg_rdata (reg_rdata)
  );

endmodule

// File: rtl/acp_checker.sv
module acp_checker #(
  parameter int ADDR_W = 32,
  parameter int NPAR   = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [NPAR-1:0]   mism,
  input logic              bus_err,
  input logic              err_sig,
  input logic              flag,
  input logic              clear_req,
  input logic [ADDR_W-1:0] cap_addr
);

  AST_ERR_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (mism != '0)) |=> bus_err); // R3

  AST_QUIET_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && (mism != '0)) |=> !bus_err); // R2

  AST_SIG_WITH_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err == err_sig); // R4

  AST_FLAG_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (mism != '0)) |=> flag); // R5

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clear_req) |=> flag); // R7

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clear_req) |=> $stable(cap_addr)); // R6

  AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && clear_req && !(req_valid && (mism != '0))) |=> !flag); // R7

endmodule

bind acp_parity_checker acp_checker #(
  .ADDR_W(ADDR_W),
  .NPAR  (NPAR)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_valid(req_valid),
  .mism     (mism),
  .bus_err  (bus_err),
  .err_sig  (err_sig),
  .flag     (flag),
  .clear_req(clear_req),
  .cap_addr (cap_addr)
);

// File: tb/acp_parity_checker_test.sv
module acp_parity_checker_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        odd_sel = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        req_wr = 1'b0;
  logic [1:0]  req_size = '0;
  logic        req_priv = 1'b0;
  logic [4:0]  req_par = '0;
  logic        bus_err;
  logic        err_sig;
  logic        reg_wr = 1'b0;
  logic        reg_idx = 1'b0;
  logic [8:0]  reg_wdata = '0;
  logic [31:0] reg_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Behavioural model state
  bit          m_err;
  bit          m_flag;
  bit [31:0]   m_addr;
  bit [7:0]    m_syn;

  always #5 clk = ~clk;

  acp_parity_checker uut (
    .clk(clk), .rst_n(rst_n), .odd_sel(odd_sel), .req_valid(req_valid),
    .req_addr(req_addr), .req_wr(req_wr), .req_size(req_size),
    .req_priv(req_priv), .req_par(req_par), .bus_err(bus_err),
    .err_sig(err_sig), .reg_wr(reg_wr), .reg_idx(reg_idx),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  // Count ones, then take the remainder
  function automatic bit ones_par(input logic [63:0] v, input int n, input bit odd);
    int c = 0;
    for (int i = 0; i < n; i++) if (v[i]) c++;
    return ((c % 2) == 1) != odd;
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Drive one address phase and register access, advance one cycle, compare
  task automatic step(input string tag, input bit v, input bit [31:0] a,
                      input bit wr, input bit [1:0] sz, input bit pr, input bit odd,
                      input bit [4:0] flip, input bit rw, input bit ridx,
                      input bit [8:0] wd);
    bit [4:0] par;
    bit       err_now, clr, swr;
    for (int g = 0; g < 4; g++)
      par[g] = ones_par(64'(a >> (8 * g)), 8, odd);
    par[4] = ones_par(64'({pr, sz, wr}), 4, odd);
    par ^= flip;
    req_valid = v; req_addr = a; req_wr = wr; req_size = sz; req_priv = pr;
    odd_sel = odd; req_par = par; reg_wr = rw; reg_idx = ridx; reg_wdata = wd;
    err_now = v && (flip != 0);
    swr = rw && !ridx;
    clr = swr && wd[8];
    m_err = err_now;
    if (err_now && (!m_flag || clr)) begin
      m_flag = 1; m_addr = a; m_syn = {3'b0, flip};
    end else begin
      if (clr) m_flag = 0;
      if (swr) m_syn &= ~wd[7:0];
    end
    @(negedge clk);
    check(m_err ? "R3" : "R2", "bus_err", 32'(bus_err), 32'(m_err));
    check("R4", "err_sig", 32'(err_sig), 32'(m_err));
    check(tag, "rdata", reg_rdata,
          ridx ? m_addr : {23'b0, m_flag, m_syn});
  endtask

  initial begin
    #(10 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    m_err = 0; m_flag = 0; m_addr = 0; m_syn = 0;
    repeat (3) @(negedge clk);
    check("R9", "bus_err in reset", 32'(bus_err), 0);
    check("R9", "status in reset", reg_rdata, 0);
    rst_n = 1'b1;
    @(negedge clk);
    reg_idx = 1'b1;
    #1 check("R9", "addr after reset", reg_rdata, 0);
    reg_idx = 1'b0;
    #1 check("R9", "status after reset", reg_rdata, 0);

    // R1/R2: correct parity, both polarities, varied data
    step("R1", 1, 32'h0000_0000, 0, 2'd0, 0, 0, 5'h00, 0, 0, 9'h0);
    step("R1", 1, 32'hFFFF_FFFF, 1, 2'd3, 1, 0, 5'h00, 0, 0, 9'h0);
    step("R10", 1, 32'h1234_5678, 1, 2'd2, 0, 1, 5'h00, 0, 0, 9'h0);
    step("R10", 1, 32'h8001_7F03, 0, 2'd1, 1, 1, 5'h00, 0, 0, 9'h0);
    step("R2", 0, 32'hDEAD_BEEF, 0, 2'd0, 0, 0, 5'h1F, 0, 0, 9'h0);
    // R1/R5: single group corruptions, cleared between
    for (int g = 0; g < 5; g++) begin
      step("R5", 1, 32'hA5C3_0F10 + g, 1, 2'd2, 0, g[0], 5'(1 << g), 0, 0, 9'h0);
      step("R1", 0, 0, 0, 0, 0, 0, 0, 0, 1, 9'h0);
      step("R7", 0, 0, 0, 0, 0, 0, 0, 1, 0, 9'h1FF);
    end
    // R5/R6: capture then a second error that must not overwrite
    step("R5", 1, 32'h0000_4440, 0, 2'd1, 1, 0, 5'h05, 0, 0, 9'h0);
    step("R6", 1, 32'h7777_0000, 1, 2'd0, 0, 1, 5'h10, 0, 1, 9'h0);
    step("R6", 0, 0, 0, 0, 0, 0, 0, 0, 0, 9'h0);
    // R7: non-clearing writes
    step("R7", 0, 0, 0, 0, 0, 0, 0, 1, 0, 9'h0FF);
    step("R7", 0, 0, 0, 0, 0, 0, 0, 1, 1, 9'h1FF);
    step("R7", 0, 0, 0, 0, 0, 0, 0, 0, 1, 9'h0);
    // R8: clear with a simultaneous new error
    step("R8", 1, 32'hCAFE_0001, 0, 2'd3, 1, 1, 5'h02, 1, 0, 9'h100);
    step("R8", 0, 0, 0, 0, 0, 0, 0, 0, 1, 9'h0);
    step("R7", 0, 0, 0, 0, 0, 0, 0, 1, 0, 9'h100);
    // Random mix
    for (int i = 0; i < 2000; i++) begin
      bit [4:0] f;
      f = ($urandom_range(0, 3) == 0) ? 5'($urandom_range(1, 31)) : 5'h0;
      step("R6", 1'($urandom), $urandom, 1'($urandom), 2'($urandom),
           1'($urandom), 1'($urandom), f, ($urandom_range(0, 9) == 0),
           1'($urandom), 9'($urandom));
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule